// File: doc/BRIEF.md
# Four-Lane Receive Packet Checker and Slice Merger

This block sits on the receive side of a four-lane serial memory link. Each lane delivers one 72-bit word per clock: an 8-bit control code above 64 data bits. The block frames each lane's packets and checks every packet with a CRC-8. Payload words are paired into 128-bit slices in a per-lane buffer. A slice is only released once its packet has passed the check, and a failed packet is rolled back out of the buffer.

When all four lanes have finished a packet, a judge takes one result from each lane and produces a single integrity verdict (ack or nak) for the local transmitter. If the verdict is an ack, the judge streams the lanes' slices out as 512-bit words, with lane 0 in the low bits. Lane 0 also carries short control packets. Acknowledgements received from the far end are passed to the retry logic, and flow-control credit updates are reported separately. Neither kind ever enters the data buffers.

Top module: `rx_packet_merge`

## Requirements
- R1: Lane k's word is `rx_word_i[72k+71 : 72k]`, control code in the top 8 bits. The codes are 0x00 idle, 0xFB start (header word), 0x01 body, and 0xFD end. A data packet is a start word, then 2·L body words, then an end word. Each pair of body words forms one slice, with the first word in slice bits [63:0].
- R2: The CRC is CRC-8 with polynomial 0x07 and an initial value of 0. It runs over every bit of the header and body data words, most significant bit first, and must equal bits [7:0] of the end word. A lane packet that fails the check leaves no slice behind, and its group's verdict is a nak.
- R3: After an ack verdict, the group's slices leave as L consecutive merged words, starting the cycle after the verdict. Each word is {lane3, lane2, lane1, lane0} at the same slice index, and `merged_last_o` is set on the final word only.
- R4: For each group of four lane data packets, exactly one verdict is issued, two cycles after the last lane's end word. It is an ack only if all four lanes pass. The verdict carries the sequence number from bits [47:40] of lane 0's header.
- R5: Header bits [7:0] hold L, the length in slices. A group is a nak, and produces no merged word, if any lane's L differs from lane 0's, if any lane's body count differs from 2·L, or if L is 0.
- R6: Lane 0 header bits [63:56] hold the kind: 0x01 data, 0x02 ack, 0x03 nak, 0x04 credit. On lanes 1 to 3 the kind is ignored. An ack or nak packet on lane 0 that passes its CRC raises a one-cycle retry pulse the cycle after its end word, with `retry_nak_o` and the header sequence. A control packet that fails its CRC is dropped without a verdict.
- R7: A credit packet on lane 0 raises a one-cycle `credit_valid_o` carrying header bits [31:16]. It produces no verdict and no merged word.
- R8: In reset and on leaving it, all valid outputs are low.
- R9: Merging waits for the slowest lane: a lane that starts late delays the verdict and the data, and does not change them.
- R10: A verdict and a retry pulse that fall in the same cycle are both issued with correct values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word_i | input | 288 | Four lane words, each {control[7:0], data[63:0]} |
| merged_valid_o | output | 1 | Merged word valid |
| merged_data_o | output | 512 | Merged word {lane3..lane0 slices} |
| merged_last_o | output | 1 | Final merged word of a packet |
| verdict_valid_o | output | 1 | Integrity verdict pulse |
| verdict_ack_o | output | 1 | 1 ack, 0 nak |
| verdict_seq_o | output | 8 | Sequence of the judged packet |
| retry_valid_o | output | 1 | Received ack/nak pulse |
| retry_nak_o | output | 1 | 1 when the received packet is a nak |
| retry_seq_o | output | 8 | Sequence carried by the received ack/nak |
| credit_valid_o | output | 1 | Received credit update pulse |
| credit_value_o | output | 16 | Credit value |

## Verification
The judge's verdict for a data group and lane 0's retry pulse for a received acknowledgement come from separate logic. Both can land in the same cycle. The bench provokes this by holding lanes 1 to 3 back by three cycles. Lane 0 therefore finishes its data packet early and then sends an ack. That ack's end word arrives exactly one cycle after the slowest lane's end word. The bench records the cycle of every output event and requires both events to carry the same cycle stamp, with the expected ack and sequence values on each.

// File: rtl/rx_merge_pkg.sv
`timescale 1ns/1ps
package rx_merge_pkg;
    localparam logic [7:0] CTL_IDLE  = 8'h00;
    localparam logic [7:0] CTL_START = 8'hFB;
    localparam logic [7:0] CTL_BODY  = 8'h01;
    localparam logic [7:0] CTL_END   = 8'hFD;

    localparam logic [7:0] KIND_DATA   = 8'h01;
    localparam logic [7:0] KIND_ACK    = 8'h02;
    localparam logic [7:0] KIND_NAK    = 8'h03;
    localparam logic [7:0] KIND_CREDIT = 8'h04;

    localparam logic [7:0] CRC_POLY = 8'h07;

    typedef enum logic {LN_IDLE, LN_BODY} lane_st_e;
    typedef enum logic {MG_WAIT, MG_DRAIN} merge_st_e;

    typedef struct packed {
        logic       good;
        logic [7:0] len;
        logic [7:0] seq;
    } lane_res_t;
endpackage

// File: rtl/rx_lane_analyzer.sv
`timescale 1ns/1ps
module rx_lane_analyzer
    import rx_merge_pkg::*;
#(
    parameter int WORD_W      = 64,
    parameter int SLICE_DEPTH = 8,
    parameter int RES_DEPTH   = 4,
    parameter bit IS_LEAD     = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WORD_W+7:0]     word_i,
    input  logic                  slice_pop_i,
    output logic [2*WORD_W-1:0]   slice_o,
    input  logic                  res_pop_i,
    output logic                  res_avail_o,
    output lane_res_t             res_o,
    output logic                  ctl_valid_o,
    output logic [7:0]            ctl_kind_o,
    output logic [7:0]            ctl_seq_o,
    output logic [15:0]           ctl_credit_o
);
    localparam int SW    = 2 * WORD_W;
    localparam int PW    = $clog2(SLICE_DEPTH);
    localparam int RW    = $clog2(RES_DEPTH);
    localparam int CNT_W = 10;

    typedef logic [PW-1:0]    sptr_t;
    typedef logic [RW:0]      rptr_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        lane_st_e          st;
        logic [7:0]        kind;
        logic [7:0]        seq;
        logic [15:0]       credit;
        logic [7:0]        len;
        logic [7:0]        crc;
        cnt_t              words;
        logic              half;
        logic [WORD_W-1:0] lo;
        sptr_t             wr_ptr;
        sptr_t             commit_ptr;
        sptr_t             rd_ptr;
        rptr_t             res_wr;
        rptr_t             res_rd;
        logic              ctl_valid;
    } lane_q_t;

    function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [WORD_W-1:0] d);
        logic [7:0] r;
        r = c;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (r[7] ^ d[i]) r = {r[6:0], 1'b0} ^ CRC_POLY;
            else             r = {r[6:0], 1'b0};
        end
        return r;
    endfunction

    lane_q_t   q, d;
    logic [SW-1:0] slice_mem [SLICE_DEPTH];
    lane_res_t     res_mem   [RES_DEPTH];
    logic          slice_we, res_we;
    logic [SW-1:0] slice_wdata;
    lane_res_t     res_wdata;
    logic          crc_ok, len_ok, is_data;

    logic [7:0]        ctl;
    logic [WORD_W-1:0] dat;
    assign ctl = word_i[WORD_W+7:WORD_W];
    assign dat = word_i[WORD_W-1:0];

    always_comb begin
        d           = q;
        d.ctl_valid = 1'b0;
        slice_we    = 1'b0;
        slice_wdata = {dat, q.lo};
        res_we      = 1'b0;
        crc_ok      = (q.crc == dat[7:0]);
        len_ok      = (q.len != 8'd0) && (q.words == cnt_t'({q.len, 1'b0})) && !q.half;
        is_data     = !IS_LEAD || (q.kind == KIND_DATA);
        res_wdata   = '{good: crc_ok && len_ok, len: q.len, seq: q.seq};

        if (slice_pop_i) d.rd_ptr = q.rd_ptr + sptr_t'(1);
        if (res_pop_i)   d.res_rd = q.res_rd + rptr_t'(1);

        if (ctl == CTL_START) begin
            d.st     = LN_BODY;
            d.wr_ptr = q.commit_ptr;
            d.kind   = dat[63:56];
            d.seq    = dat[47:40];
            d.credit = dat[31:16];
            d.len    = dat[7:0];
            d.crc    = crc_step(8'h00, dat);
            d.words  = '0;
            d.half   = 1'b0;
        end else if (ctl == CTL_BODY && q.st == LN_BODY) begin
            d.crc   = crc_step(q.crc, dat);
            d.words = q.words + cnt_t'(1);
            if (!q.half) begin
                d.lo   = dat;
                d.half = 1'b1;
            end else begin
                slice_we = 1'b1;
                d.wr_ptr = q.wr_ptr + sptr_t'(1);
                d.half   = 1'b0;
            end
        end else if (ctl == CTL_END && q.st == LN_BODY) begin
            d.st = LN_IDLE;
            if (is_data) begin
                res_we   = 1'b1;
                d.res_wr = q.res_wr + rptr_t'(1);
                if (res_wdata.good) d.commit_ptr = q.wr_ptr;
                else                d.wr_ptr     = q.commit_ptr;
            end else begin
                d.wr_ptr = q.commit_ptr;
                if (crc_ok && (q.kind == KIND_ACK || q.kind == KIND_NAK || q.kind == KIND_CREDIT))
                    d.ctl_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (slice_we) slice_mem[q.wr_ptr] <= slice_wdata;
        if (res_we)   res_mem[q.res_wr[RW-1:0]] <= res_wdata;
    end

    assign slice_o      = slice_mem[q.rd_ptr];
    assign res_o        = res_mem[q.res_rd[RW-1:0]];
    assign res_avail_o  = (q.res_wr != q.res_rd);
    assign ctl_valid_o  = q.ctl_valid;
    assign ctl_kind_o   = q.kind;
    assign ctl_seq_o    = q.seq;
    assign ctl_credit_o = q.credit;
endmodule

// File: rtl/rx_lane_merger.sv
`timescale 1ns/1ps
module rx_lane_merger
    import rx_merge_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int SLICE_W = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES-1:0]           res_avail_i,
    input  lane_res_t [LANES-1:0]      res_i,
    output logic [LANES-1:0]           res_pop_o,
    input  logic [LANES*SLICE_W-1:0]   slice_i,
    output logic [LANES-1:0]           slice_pop_o,
    output logic                       merged_valid_o,
    output logic [LANES*SLICE_W-1:0]   merged_data_o,
    output logic                       merged_last_o,
    output logic                       verdict_valid_o,
    output logic                       verdict_ack_o,
    output logic [7:0]                 verdict_seq_o
);
    localparam int OUT_W = LANES * SLICE_W;

    typedef struct packed {
        merge_st_e               st;
        logic                    good;
        logic [LANES-1:0][7:0]   rem;
        logic                    out_valid;
        logic                    out_last;
        logic [OUT_W-1:0]        out_data;
        logic                    v_valid;
        logic                    v_ack;
        logic [7:0]              v_seq;
    } merge_q_t;

    merge_q_t q, d;
    logic     all_pass, busy;

    always_comb begin
        d           = q;
        d.out_valid = 1'b0;
        d.out_last  = 1'b0;
        d.v_valid   = 1'b0;
        res_pop_o   = '0;
        slice_pop_o = '0;
        all_pass    = 1'b1;
        busy        = 1'b0;
        unique case (q.st)
            MG_WAIT: begin
                if (&res_avail_i) begin
                    res_pop_o = '1;
                    for (int k = 0; k < LANES; k++) begin
                        if (!res_i[k].good || res_i[k].len != res_i[0].len) all_pass = 1'b0;
                        d.rem[k] = res_i[k].good ? res_i[k].len : 8'd0;
                        if (d.rem[k] != 8'd0) busy = 1'b1;
                    end
                    d.v_valid = 1'b1;
                    d.v_ack   = all_pass;
                    d.v_seq   = res_i[0].seq;
                    d.good    = all_pass;
                    d.st      = busy ? MG_DRAIN : MG_WAIT;
                end
            end
            MG_DRAIN: begin
                for (int k = 0; k < LANES; k++) begin
                    if (q.rem[k] != 8'd0) begin
                        slice_pop_o[k] = 1'b1;
                        d.rem[k]       = q.rem[k] - 8'd1;
                    end
                    if (d.rem[k] != 8'd0) busy = 1'b1;
                end
                d.out_data  = slice_i;
                d.out_valid = q.good;
                d.out_last  = q.good && (q.rem[0] == 8'd1);
                if (!busy) d.st = MG_WAIT;
            end
            default: d.st = MG_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign merged_valid_o  = q.out_valid;
    assign merged_data_o   = q.out_data;
    assign merged_last_o   = q.out_last;
    assign verdict_valid_o = q.v_valid;
    assign verdict_ack_o   = q.v_ack;
    assign verdict_seq_o   = q.v_seq;
endmodule

// File: rtl/rx_packet_merge.sv
`timescale 1ns/1ps
module rx_packet_merge
    import rx_merge_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int WORD_W      = 64,
    parameter int SLICE_DEPTH = 8,
    parameter int RES_DEPTH   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES*(WORD_W+8)-1:0]   rx_word_i,
    output logic                          merged_valid_o,
    output logic [LANES*2*WORD_W-1:0]     merged_data_o,
    output logic                          merged_last_o,
    output logic                          verdict_valid_o,
    output logic                          verdict_ack_o,
    output logic [7:0]                    verdict_seq_o,
    output logic                          retry_valid_o,
    output logic                          retry_nak_o,
    output logic [7:0]                    retry_seq_o,
    output logic                          credit_valid_o,
    output logic [15:0]                   credit_value_o
);
    localparam int LANE_W  = WORD_W + 8;
    localparam int SLICE_W = 2 * WORD_W;

    logic [LANES-1:0]          slice_pop, res_pop, res_avail, ctl_valid;
    logic [LANES*SLICE_W-1:0]  slices;
    lane_res_t [LANES-1:0]     res;
    logic [7:0]                ctl_kind   [LANES];
    logic [7:0]                ctl_seq    [LANES];
    logic [15:0]               ctl_credit [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rx_lane_analyzer #(
            .WORD_W      (WORD_W),
            .SLICE_DEPTH (SLICE_DEPTH),
            .RES_DEPTH   (RES_DEPTH),
            .IS_LEAD     (g == 0)
        ) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .word_i       (rx_word_i[g*LANE_W +: LANE_W]),
            .slice_pop_i  (slice_pop[g]),
            .slice_o      (slices[g*SLICE_W +: SLICE_W]),
            .res_pop_i    (res_pop[g]),
            .res_avail_o  (res_avail[g]),
            .res_o        (res[g]),
            .ctl_valid_o  (ctl_valid[g]),
            .ctl_kind_o   (ctl_kind[g]),
            .ctl_seq_o    (ctl_seq[g]),
            .ctl_credit_o (ctl_credit[g])
        );
    end

    rx_lane_merger #(
        .LANES   (LANES),
        .SLICE_W (SLICE_W)
    ) u_merge (
        .clk             (clk),
        .rst_n           (rst_n),
        .res_avail_i     (res_avail),
        .res_i           (res),
        .res_pop_o       (res_pop),
        .slice_i         (slices),
        .slice_pop_o     (slice_pop),
        .merged_valid_o  (merged_valid_o),
        .merged_data_o   (merged_data_o),
        .merged_last_o   (merged_last_o),
        .verdict_valid_o (verdict_valid_o),
        .verdict_ack_o   (verdict_ack_o),
        .verdict_seq_o   (verdict_seq_o)
    );

    // Control events: only the lead lane ever raises ctl_valid.
    always_comb begin
        retry_valid_o  = 1'b0;
        retry_nak_o    = 1'b0;
        retry_seq_o    = 8'h00;
        credit_valid_o = 1'b0;
        credit_value_o = 16'h0000;
        for (int k = 0; k < LANES; k++) begin
            if (ctl_valid[k]) begin
                if (ctl_kind[k] == KIND_CREDIT) begin
                    credit_valid_o = 1'b1;
                    credit_value_o = ctl_credit[k];
                end else begin
                    retry_valid_o = 1'b1;
                    retry_nak_o   = (ctl_kind[k] == KIND_NAK);
                    retry_seq_o   = ctl_seq[k];
                end
            end
        end
    end
endmodule

// File: rtl/rx_packet_merge_chk.sv
`timescale 1ns/1ps
module rx_packet_merge_chk (
    input logic clk,
    input logic rst_n,
    input logic merged_valid_o,
    input logic merged_last_o,
    input logic verdict_valid_o,
    input logic verdict_ack_o,
    input logic retry_valid_o,
    input logic credit_valid_o
);
    p_quiet_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !merged_valid_o && !verdict_valid_o && !retry_valid_o && !credit_valid_o);

    p_last_in_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        merged_last_o |-> merged_valid_o);

    p_ack_starts_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid_o && verdict_ack_o |=> merged_valid_o);

    p_nak_withholds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid_o && !verdict_ack_o |=> !merged_valid_o);

    p_retry_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retry_valid_o |=> !retry_valid_o);

    p_credit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        credit_valid_o |=> !credit_valid_o);
endmodule

bind rx_packet_merge rx_packet_merge_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .merged_valid_o  (merged_valid_o),
    .merged_last_o   (merged_last_o),
    .verdict_valid_o (verdict_valid_o),
    .verdict_ack_o   (verdict_ack_o),
    .retry_valid_o   (retry_valid_o),
    .credit_valid_o  (credit_valid_o)
);

// File: tb/test_rx_packet_merge.sv
`timescale 1ns/1ps
module test_rx_packet_merge;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [287:0] rx_word;
    logic         merged_valid, merged_last, verdict_valid, verdict_ack;
    logic [511:0] merged_data;
    logic [7:0]   verdict_seq, retry_seq;
    logic         retry_valid, retry_nak, credit_valid;
    logic [15:0]  credit_value;

    always #2 clk = ~clk;

    rx_packet_merge i_rx_packet_merge (
        .clk(clk), .rst_n(rst_n), .rx_word_i(rx_word),
        .merged_valid_o(merged_valid), .merged_data_o(merged_data), .merged_last_o(merged_last),
        .verdict_valid_o(verdict_valid), .verdict_ack_o(verdict_ack), .verdict_seq_o(verdict_seq),
        .retry_valid_o(retry_valid), .retry_nak_o(retry_nak), .retry_seq_o(retry_seq),
        .credit_valid_o(credit_valid), .credit_value_o(credit_value)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int c0     = 0;

    always @(posedge clk) cyc <= cyc + 1;

    logic [511:0] md_q[$];
    bit           ml_q[$];
    int           mc_q[$];
    bit           va_q[$];
    logic [7:0]   vs_q[$];
    int           vc_q[$];
    bit           rn_q[$];
    logic [7:0]   rs_q[$];
    int           rc_q[$];
    logic [15:0]  cv_q[$];

    always @(negedge clk) begin
        if (rst_n) begin
            if (merged_valid)  begin md_q.push_back(merged_data); ml_q.push_back(merged_last); mc_q.push_back(cyc); end
            if (verdict_valid) begin va_q.push_back(verdict_ack); vs_q.push_back(verdict_seq); vc_q.push_back(cyc); end
            if (retry_valid)   begin rn_q.push_back(retry_nak); rs_q.push_back(retry_seq); rc_q.push_back(cyc); end
            if (credit_valid)  cv_q.push_back(credit_value);
        end
    end

    task automatic flush_mon();
        md_q.delete(); ml_q.delete(); mc_q.delete();
        va_q.delete(); vs_q.delete(); vc_q.delete();
        rn_q.delete(); rs_q.delete(); rc_q.delete(); cv_q.delete();
    endtask

    task automatic chk(input string req, input string what, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] crc8(input logic [7:0] c, input logic [63:0] d);
        logic [7:0] r = c;
        for (int i = 63; i >= 0; i--) r = (r[7] ^ d[i]) ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
        return r;
    endfunction

    function automatic logic [127:0] slice_val(input int ln, input int tag, input int idx);
        return {4{8'(ln), 8'(tag), 8'(idx), 8'h5A}};
    endfunction

    function automatic logic [511:0] exp_word(input int tag, input int idx);
        return {slice_val(3, tag, idx), slice_val(2, tag, idx), slice_val(1, tag, idx), slice_val(0, tag, idx)};
    endfunction

    logic [71:0] seq_mem [4][48];
    int          seq_len [4];

    task automatic clear_seq();
        for (int k = 0; k < 4; k++) seq_len[k] = 0;
    endtask

    task automatic put(input int ln, input logic [7:0] c, input logic [63:0] d);
        seq_mem[ln][seq_len[ln]] = {c, d};
        seq_len[ln]++;
    endtask

    task automatic idle(input int ln, input int n);
        for (int i = 0; i < n; i++) put(ln, 8'h00, 64'h0);
    endtask

    task automatic add_data(input int ln, input int hdr_len, input int n_sl, input logic [7:0] sq,
                            input int tag, input bit bad);
        logic [63:0]  h;
        logic [7:0]   c;
        logic [127:0] s;
        h = {8'h01, 8'h00, sq, 8'h00, 16'h0000, 8'h00, 8'(hdr_len)};
        c = crc8(8'h00, h);
        put(ln, 8'hFB, h);
        for (int i = 0; i < n_sl; i++) begin
            s = slice_val(ln, tag, i);
            put(ln, 8'h01, s[63:0]);   c = crc8(c, s[63:0]);
            put(ln, 8'h01, s[127:64]); c = crc8(c, s[127:64]);
        end
        put(ln, 8'hFD, {56'h0, c ^ (bad ? 8'hFF : 8'h00)});
    endtask

    task automatic add_ctl(input logic [7:0] kind, input logic [7:0] sq, input logic [15:0] cr, input bit bad);
        logic [63:0] h;
        h = {kind, 8'h00, sq, 8'h00, cr, 8'h00, 8'h00};
        put(0, 8'hFB, h);
        put(0, 8'hFD, {56'h0, crc8(8'h00, h) ^ (bad ? 8'hFF : 8'h00)});
    endtask

    task automatic play();
        int mx = 0;
        flush_mon();
        for (int k = 0; k < 4; k++) if (seq_len[k] > mx) mx = seq_len[k];
        for (int i = 0; i < mx; i++) begin
            @(negedge clk);
            if (i == 0) c0 = cyc;
            for (int k = 0; k < 4; k++) rx_word[k*72 +: 72] = (i < seq_len[k]) ? seq_mem[k][i] : 72'h0;
        end
        @(negedge clk);
        rx_word = '0;
        repeat (14) @(negedge clk);
        clear_seq();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rx_word = '0; clear_seq();
        repeat (4) @(negedge clk);
        chk("R8", "valids in reset", {merged_valid, verdict_valid, retry_valid, credit_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "valids after release", {merged_valid, verdict_valid, retry_valid, credit_valid}, 0);
    endtask

    task automatic t_basic();
        for (int k = 0; k < 4; k++) add_data(k, 2, 2, 8'h11, 1, 1'b0);
        play();
        chk("R4", "verdict count", va_q.size(), 1);
        chk("R4", "verdict ack", va_q[0], 1);
        chk("R4", "verdict seq", vs_q[0], 8'h11);
        chk("R4", "verdict cycle", vc_q[0], c0 + 7);
        chk("R3", "merged count", md_q.size(), 2);
        chk("R1", "merged word 0", md_q[0], exp_word(1, 0));
        chk("R3", "merged word 1", md_q[1], exp_word(1, 1));
        chk("R3", "last flags", {ml_q[0], ml_q[1]}, 2'b01);
        chk("R3", "first word cycle", mc_q[0], c0 + 8);
    endtask

    task automatic t_skew();
        idle(2, 6);
        for (int k = 0; k < 4; k++) add_data(k, 1, 1, 8'h22, 2, 1'b0);
        play();
        chk("R9", "verdict waits for late lane", vc_q[0], c0 + 11);
        chk("R9", "verdict ack", va_q[0], 1);
        chk("R9", "merged word", md_q[0], exp_word(2, 0));
        chk("R9", "merged count", md_q.size(), 1);
    endtask

    task automatic t_crc();
        for (int k = 0; k < 4; k++) add_data(k, 1, 1, 8'h33, 3, k == 1);
        play();
        chk("R2", "bad crc verdict", {va_q.size(), va_q[0], vs_q[0]}, {32'd1, 1'b0, 8'h33});
        chk("R2", "bad crc no data", md_q.size(), 0);
        for (int k = 0; k < 4; k++) add_data(k, 1, 1, 8'h44, 4, 1'b0);
        play();
        chk("R2", "recovery ack", {va_q.size(), va_q[0]}, {32'd1, 1'b1});
        chk("R2", "recovery data has no stale slice", md_q[0], exp_word(4, 0));
    endtask

    task automatic t_len();
        for (int k = 0; k < 4; k++) add_data(k, (k == 3) ? 1 : 2, (k == 3) ? 1 : 2, 8'h55, 5, 1'b0);
        play();
        chk("R5", "cross-lane length nak", {va_q.size(), va_q[0]}, {32'd1, 1'b0});
        chk("R5", "cross-lane no data", md_q.size(), 0);
        for (int k = 0; k < 4; k++) add_data(k, 2, (k == 2) ? 1 : 2, 8'h56, 6, 1'b0);
        play();
        chk("R5", "body count nak", {va_q.size(), va_q[0]}, {32'd1, 1'b0});
        chk("R5", "body count no data", md_q.size(), 0);
        for (int k = 0; k < 4; k++) add_data(k, 1, 1, 8'h57, 7, 1'b0);
        play();
        chk("R5", "follow-up data clean", {md_q.size(), md_q[0]}, {32'd1, exp_word(7, 0)});
    endtask

    task automatic t_retry();
        add_ctl(8'h02, 8'h5A, 16'h0, 1'b0);
        add_ctl(8'h03, 8'hA5, 16'h0, 1'b0);
        add_ctl(8'h02, 8'h77, 16'h0, 1'b1);
        play();
        chk("R6", "retry count (bad one dropped)", rn_q.size(), 2);
        chk("R6", "ack event", {rn_q[0], rs_q[0]}, {1'b0, 8'h5A});
        chk("R6", "nak event", {rn_q[1], rs_q[1]}, {1'b1, 8'hA5});
        chk("R6", "retry cycles", {rc_q[0], rc_q[1]}, {c0 + 2, c0 + 4});
        chk("R6", "no verdict from control", va_q.size(), 0);
    endtask

    task automatic t_credit();
        add_ctl(8'h04, 8'h00, 16'h1234, 1'b0);
        play();
        chk("R7", "credit event", {cv_q.size(), cv_q[0]}, {32'd1, 16'h1234});
        chk("R7", "credit no verdict/data", {va_q.size(), md_q.size()}, 0);
    endtask

    task automatic t_collide();
        add_data(0, 1, 1, 8'h66, 8, 1'b0);
        idle(0, 2);
        add_ctl(8'h02, 8'h99, 16'h0, 1'b0);
        for (int k = 1; k < 4; k++) begin idle(k, 3); add_data(k, 1, 1, 8'h66, 8, 1'b0); end
        play();
        chk("R10", "verdict and retry same cycle", {vc_q[0], rc_q[0]}, {c0 + 8, c0 + 8});
        chk("R10", "verdict value", {va_q[0], vs_q[0]}, {1'b1, 8'h66});
        chk("R10", "retry value", {rn_q[0], rs_q[0]}, {1'b0, 8'h99});
        chk("R10", "merged word", md_q[0], exp_word(8, 0));
    endtask

    initial begin
        t_reset();
        t_basic();
        t_skew();
        t_crc();
        t_len();
        t_retry();
        t_credit();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule